// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block sits in a processor debug subsystem and holds a small, parameterized bank of instruction-address comparators. Software programs one address register per comparator and a shared arming register through a simple write port. The unit compares each armed address against the current program counter. It raises a single hit flag together with the index of the comparator that matched.

The comparison is exact, so every address bit takes part. A hit is withheld whenever the current interrupt level is at or above the configured debug level. This lets a debug handler run without re-triggering the breakpoints. When several comparators match at once, the lowest-numbered one is reported.

The hit path is purely combinational from the program counter and level inputs. Register updates take effect on the clock edge. A read port returns the stored register contents.

Top module: `ibrk_unit`

## Requirements
- R1: A write with `wr_sel`=1 loads the arming register from the low NUM_CMP bits of `wr_data` and discards the rest. A read with `rd_sel`=1 returns the arming bits in `rd_data[NUM_CMP-1:0]`, with zeros above them.
- R2: A write with `wr_sel`=0 loads the address register selected by `wr_idx` from `wr_data`. From the following cycle, a read with `rd_sel`=0 and `rd_idx` set to that index returns the value written.
- R3: Comparator i matches only when arming bit i is 1 and its address register equals `pc` in every bit. An address that differs in any single bit gives no hit.
- R4: `hit` stays 0 while `cur_lvl` >= DEBUG_LVL. With `cur_lvl` = DEBUG_LVL-1, a matching armed comparator gives a hit.
- R5: When several comparators match together, `hit_idx` is the lowest matching index.
- R6: Rewriting the address of an armed comparator replaces the old address from the next cycle. The new address hits and the old one does not.
- R7: Clearing an arming bit stops that comparator from hitting from the next cycle. Setting the bit again arms it with the address already held.
- R8: After reset, the arming register and all address registers read zero, and no hit is reported, even for `pc`=0.
- R9: `hit` and `hit_idx` follow `pc` and `cur_lvl` within the same cycle, with no clock edge needed. `hit_idx` is 0 whenever `hit` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 1 = arming register, 0 = address register |
| wr_idx | input | IDX_W | Comparator index for address writes |
| wr_data | input | ADDR_W | Write data |
| rd_sel | input | 1 | Read target: 1 = arming register, 0 = address register |
| rd_idx | input | IDX_W | Comparator index for address reads |
| rd_data | output | ADDR_W | Read data |
| pc | input | ADDR_W | Current program counter |
| cur_lvl | input | LVL_W | Current interrupt level |
| hit | output | 1 | Breakpoint hit |
| hit_idx | output | IDX_W | Lowest matching comparator index, 0 when no hit |

## Verification
The assertions assume that the program counter, the level, the read selection and the write inputs are stable around each rising clock edge. Under that assumption, the values sampled at the edge are the ones that the combinational outputs settled on. They also assume that read and write indices name an implemented comparator. The stimulus changes every input only just after the falling edge and uses only indices 0 to NUM_CMP-1, so both assumptions hold throughout the run.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
  typedef enum logic {
    SEL_ADDR   = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ibrk_rst_sync.sv
module ibrk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ibrk_regs.sv
module ibrk_regs
  import ibrk_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 2
) (
  input  logic                             clk,
  input  logic                             srst_n,
  input  logic                             wr_en,
  input  logic                             wr_sel,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [ADDR_W-1:0]                wr_data,
  output logic [NUM_CMP-1:0]               en_o,
  output logic [NUM_CMP-1:0][ADDR_W-1:0]   addr_o
);
  reg_sel_e             sel;
  logic                 en_ce;
  logic [NUM_CMP-1:0]   en_d;
  logic [NUM_CMP-1:0]   en_q;

  always_comb begin
    sel   = reg_sel_e'(wr_sel);
    en_ce = wr_en && (sel == SEL_ENABLE);
    en_d  = wr_data[NUM_CMP-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_addr
    logic              ce;
    logic [ADDR_W-1:0] d;
    logic [ADDR_W-1:0] q;

    always_comb begin
      ce = wr_en && (sel == SEL_ADDR) && (wr_idx == IDX_W'(g));
      d  = wr_data;
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) q <= '0;
      else if (ce) q <= d;
    end

    assign addr_o[g] = q;
  end
endmodule

// File: rtl/ibrk_cmp.sv
module ibrk_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              match_o
);
  always_comb begin
    match_o = en_i && (addr_i == pc_i);
  end
endmodule

// File: rtl/ibrk_prio.sv
module ibrk_prio #(
  parameter int NUM_CMP   = 4,
  parameter int IDX_W     = 2,
  parameter int LVL_W     = 4,
  parameter int DEBUG_LVL = 6
) (
  input  logic [NUM_CMP-1:0] match_i,
  input  logic [LVL_W-1:0]   lvl_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic             allow;
  logic [IDX_W-1:0] first;

  always_comb begin
    allow = ({1'b0, lvl_i} < (LVL_W+1)'(DEBUG_LVL));
    first = '0;
    for (int i = NUM_CMP - 1; i >= 0; i--) begin
      if (match_i[i]) first = IDX_W'(i);
    end
    hit_o = allow && (|match_i);
    idx_o = hit_o ? first : '0;
  end
endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit
  import ibrk_pkg::*;
#(
  parameter int NUM_CMP   = 4,
  parameter int ADDR_W    = 32,
  parameter int LVL_W     = 4,
  parameter int DEBUG_LVL = 6,
  localparam int IDX_W    = idx_width(NUM_CMP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              rd_sel,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] pc,
  input  logic [LVL_W-1:0]  cur_lvl,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic                           srst_n;
  logic [NUM_CMP-1:0]             en_q;
  logic [NUM_CMP-1:0][ADDR_W-1:0] addr_q;
  logic [NUM_CMP-1:0]             match_vec;

  ibrk_rst_sync rst_sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ibrk_regs #(
    .NUM_CMP (NUM_CMP),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
  ) regs_i (
    .clk     (clk),
    .srst_n  (srst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .en_o    (en_q),
    .addr_o  (addr_q)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    ibrk_cmp #(.ADDR_W(ADDR_W)) cmp_i (
      .en_i    (en_q[g]),
      .addr_i  (addr_q[g]),
      .pc_i    (pc),
      .match_o (match_vec[g])
    );
  end

  ibrk_prio #(
    .NUM_CMP   (NUM_CMP),
    .IDX_W     (IDX_W),
    .LVL_W     (LVL_W),
    .DEBUG_LVL (DEBUG_LVL)
  ) prio_i (
    .match_i (match_vec),
    .lvl_i   (cur_lvl),
    .hit_o   (hit),
    .idx_o   (hit_idx)
  );

  always_comb begin
    if (reg_sel_e'(rd_sel) == SEL_ENABLE)  rd_data = ADDR_W'(en_q);
    else if (int'(rd_idx) < NUM_CMP)        rd_data = addr_q[rd_idx];
    else                                    rd_data = '0;
  end
endmodule

// File: rtl/ibrk_unit_chk.sv
module ibrk_unit_chk #(
  parameter int NUM_CMP   = 4,
  parameter int ADDR_W    = 32,
  parameter int LVL_W     = 4,
  parameter int DEBUG_LVL = 6,
  parameter int IDX_W     = 2
) (
  input logic               clk,
  input logic               srst_n,
  input logic               wr_en,
  input logic               wr_sel,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [ADDR_W-1:0]  wr_data,
  input logic               rd_sel,
  input logic [IDX_W-1:0]   rd_idx,
  input logic [ADDR_W-1:0]  rd_data,
  input logic [LVL_W-1:0]   cur_lvl,
  input logic [NUM_CMP-1:0] match_vec,
  input logic               hit,
  input logic [IDX_W-1:0]   hit_idx
);
  localparam logic [ADDR_W-1:0] EN_MASK = {ADDR_W{1'b1}} >> (ADDR_W - NUM_CMP);

  logic level_ok;
  logic [NUM_CMP-1:0] below_mask;

  always_comb begin
    level_ok   = ({1'b0, cur_lvl} < (LVL_W+1)'(DEBUG_LVL));
    below_mask = (NUM_CMP'(1) << hit_idx) - NUM_CMP'(1);
  end

  assert_en_upper_zero_R1: assert property (@(posedge clk) disable iff (!srst_n)
    rd_sel |-> ((rd_data & ~EN_MASK) == '0));

  assert_en_write_R1: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && wr_sel) |=> (!rd_sel || rd_data == $past(wr_data & EN_MASK)));

  assert_addr_write_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && !wr_sel) |=> (rd_sel || rd_idx != $past(wr_idx) || rd_data == $past(wr_data)));

  assert_hit_source_R3: assert property (@(posedge clk) disable iff (!srst_n)
    hit |-> match_vec[hit_idx]);

  assert_match_gives_hit_R3: assert property (@(posedge clk) disable iff (!srst_n)
    ((match_vec != '0) && level_ok) |-> hit);

  assert_level_block_R4: assert property (@(posedge clk) disable iff (!srst_n)
    !level_ok |-> !hit);

  assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!srst_n)
    hit |-> ((match_vec & below_mask) == '0));

  assert_idle_index_R9: assert property (@(posedge clk) disable iff (!srst_n)
    !hit |-> (hit_idx == '0));
endmodule

bind ibrk_unit ibrk_unit_chk #(
  .NUM_CMP   (NUM_CMP),
  .ADDR_W    (ADDR_W),
  .LVL_W     (LVL_W),
  .DEBUG_LVL (DEBUG_LVL),
  .IDX_W     (IDX_W)
) chk_i (
  .clk       (clk),
  .srst_n    (srst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .rd_sel    (rd_sel),
  .rd_idx    (rd_idx),
  .rd_data   (rd_data),
  .cur_lvl   (cur_lvl),
  .match_vec (match_vec),
  .hit       (hit),
  .hit_idx   (hit_idx)
);

// File: tb/ibrk_unit_tb_top.sv
module ibrk_unit_tb_top;
  localparam int NUM_CMP = 4;
  localparam int ADDR_W  = 32;
  localparam int LVL_W   = 4;
  localparam int DBG     = 6;
  localparam int IDX_W   = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic              wr_sel;
  logic [IDX_W-1:0]  wr_idx;
  logic [ADDR_W-1:0] wr_data;
  logic              rd_sel;
  logic [IDX_W-1:0]  rd_idx;
  logic [ADDR_W-1:0] rd_data;
  logic [ADDR_W-1:0] pc;
  logic [LVL_W-1:0]  cur_lvl;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  ibrk_unit #(
    .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .LVL_W(LVL_W), .DEBUG_LVL(DBG)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .pc(pc), .cur_lvl(cur_lvl), .hit(hit), .hit_idx(hit_idx)
  );

  // fields: pc[38:7], level[6:3], expected hit[2], expected index[1:0]
  localparam logic [38:0] VEC [0:7] = '{
    {32'h0000_1000, 4'd0,  1'b1, 2'd0},  // R3 exact match
    {32'h0000_2000, 4'd0,  1'b1, 2'd1},  // R5 comparators 1 and 2 both match
    {32'h0000_3004, 4'd5,  1'b1, 2'd3},  // R4 level just below debug level
    {32'h0000_3004, 4'd6,  1'b0, 2'd0},  // R4 level equal to debug level
    {32'h0000_3004, 4'd15, 1'b0, 2'd0},  // R4 level at maximum
    {32'h0000_3005, 4'd0,  1'b0, 2'd0},  // R3 low bit differs
    {32'h8000_1000, 4'd0,  1'b0, 2'd0},  // R3 top bit differs
    {32'h0000_0000, 4'd0,  1'b0, 2'd0}   // R3 no register holds zero
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [IDX_W-1:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [IDX_W-1:0] idx);
    rd_sel = sel; rd_idx = idx;
    #1;
  endtask

  task automatic probe(input logic [31:0] p, input logic [3:0] l);
    pc = p; cur_lvl = l;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_idx = '0; wr_data = '0;
    rd_sel = 1'b0; rd_idx = '0; pc = '0; cur_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state
    rd(1'b1, 2'd0);
    check("R8 enable after reset", rd_data, 32'h0);
    for (int i = 0; i < NUM_CMP; i++) begin
      rd(1'b0, IDX_W'(i));
      check("R8 address after reset", rd_data, 32'h0);
    end
    probe(32'h0, 4'd0);
    check("R8 no hit after reset", {31'b0, hit}, 32'h0);

    // program comparators
    wr(1'b0, 2'd0, 32'h0000_1000);
    wr(1'b0, 2'd1, 32'h0000_2000);
    wr(1'b0, 2'd2, 32'h0000_2000);
    wr(1'b0, 2'd3, 32'h0000_3004);
    wr(1'b1, 2'd0, 32'hFFFF_FFFF);
    rd(1'b1, 2'd0);
    check("R1 enable upper bits discarded", rd_data, 32'h0000_000F);
    rd(1'b0, 2'd2);
    check("R2 address readback", rd_data, 32'h0000_2000);
    rd(1'b0, 2'd3);
    check("R2 address readback", rd_data, 32'h0000_3004);

    // vector table
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      probe(VEC[v][38:7], VEC[v][6:3]);
      check("R3/R4/R5 table hit", {31'b0, hit}, {31'b0, VEC[v][2]});
      check("R3/R4/R5 table index", {30'b0, hit_idx}, {30'b0, VEC[v][1:0]});
    end

    // R9 combinational response with no clock edge in between
    @(negedge clk);
    probe(32'h0000_1000, 4'd0);
    check("R9 hit follows pc", {31'b0, hit}, 32'h1);
    probe(32'h0000_3004, 4'd0);
    check("R9 index follows pc", {30'b0, hit_idx}, 32'h3);
    probe(32'h0000_3004, 4'd7);
    check("R9 hit follows level", {31'b0, hit}, 32'h0);
    check("R9 idle index zero", {30'b0, hit_idx}, 32'h0);

    // R6 rewrite of an armed comparator
    wr(1'b0, 2'd3, 32'h0000_4000);
    probe(32'h0000_4000, 4'd0);
    check("R6 new address hits", {31'b0, hit}, 32'h1);
    check("R6 new address index", {30'b0, hit_idx}, 32'h3);
    probe(32'h0000_3004, 4'd0);
    check("R6 old address no hit", {31'b0, hit}, 32'h0);

    // R7 disarm and rearm
    wr(1'b1, 2'd0, 32'h0000_000D);
    probe(32'h0000_2000, 4'd0);
    check("R7 cleared bit skips comparator", {30'b0, hit_idx}, 32'h2);
    wr(1'b1, 2'd0, 32'h0000_0000);
    probe(32'h0000_1000, 4'd0);
    check("R7 all disarmed no hit", {31'b0, hit}, 32'h0);
    wr(1'b1, 2'd0, 32'h0000_0001);
    probe(32'h0000_1000, 4'd0);
    check("R7 rearm uses held address", {31'b0, hit}, 32'h1);
    check("R7 rearm index", {30'b0, hit_idx}, 32'h0);
    rd(1'b1, 2'd0);
    check("R1 enable readback", rd_data, 32'h0000_0001);

    finish_run();
  end
endmodule